// File: doc/BRIEF.md
# NAND Cache Program Engine

This block sits on the device side of an 8-bit NAND command/address/data bus and carries out page programming. A host opens a program with a setup command, sends four address bytes, streams the page bytes into a cache register, and then confirms. A cache confirm (15h) lets the host load the next page while the page before it is still being written into the array. A page confirm (10h) ends the sequence and holds the device busy until the array write has finished. Status command 70h drives a status byte onto the read bus.

Data is held in two stages. The cache register takes host bytes. The page buffer feeds a behavioural array that writes one byte per clock over a programming time set by a parameter. A page moves from the cache to the page buffer only when the array engine is idle, and the move takes a set number of cycles. A test input injects a program failure into a page. Pages of a cache sequence that leave the block of the first page, or that exceed the page limit of a sequence, are flagged as errors and are not written. A read port gives direct access to the array so that its contents can be checked.

Top module: `nand_cachepgm_ctl`

## Requirements
- R1: After reset `busy_o` is 0, `io_out` is 00h, and a status read returns E0h.
- R2: Command 80h starts a setup. Exactly four address bytes follow. The low ROW_W bits of the third byte select the page row, and the other address bytes are ignored. Data bytes that follow fill the cache in order from byte 0.
- R3: Data bytes beyond PAGE_BYTES are ignored. Page bytes that were not loaded are programmed as FFh.
- R4: After a 10h confirm, `busy_o` is 1 from the next cycle, and the page is in the array once the device is ready again.
- R5: After a 15h confirm, `busy_o` drops when the cache has been moved to the page buffer. The array keeps programming after that, so a status read right after ready shows bit 6 = 1 and bit 5 = 0.
- R6: From the second clock after a 70h command, `io_out` shows the status byte. Bit 7 is always 1, bit 6 means the cache is ready (not busy), bit 5 means the array is idle and no transfer is pending, bit 1 is the previous page error, bit 0 is the current page error, and all other bits are 0. Any other command returns `io_out` to 00h.
- R7: A page confirmed while the array is busy waits, with `busy_o` high, until the array is idle. Every page of a sequence ends up in the array unchanged.
- R8: After a 10h confirm, `busy_o` falls only when array programming has completed.
- R9: Each time an array program completes, bit 1 takes the old bit 0, and bit 0 becomes that page's error. `err_inject` is sampled when the page enters the page buffer.
- R10: In a cache sequence, a later page whose block (row / PAGES_PER_BLOCK) differs from the first page's block is an error and is not written.
- R11: A page beyond MAX_SEQ pages in one sequence is an error and is not written. A 10h confirm ends the sequence.
- R12: The array byte at `row*PAGE_BYTES + byte` appears on `mem_rd_data` one clock after it is presented on `mem_rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte strobe |
| addr_wr | input | 1 | Address byte strobe |
| data_wr | input | 1 | Data byte strobe |
| io_in | input | 8 | Bus input byte |
| err_inject | input | 1 | Forces a program failure on the page entering the page buffer |
| io_out | output | 8 | Status byte after 70h, otherwise 00h |
| busy_o | output | 1 | High while the device is busy |
| mem_rd_addr | input | MEM_AW | Array read address |
| mem_rd_data | output | 8 | Array read data |

## Verification
The assertions assume that the host strobes at most one of `cmd_wr`, `addr_wr` and `data_wr` per cycle. They also assume that, apart from 70h, the host issues no command while `busy_o` is high, and that `err_inject` is held steady from a confirm until ready returns. The stimulus respects all of this because every bus cycle comes from a task that raises one strobe for one cycle and waits on `busy_o` after each confirm. Random page counts, rows and load lengths stay within a single block, except in the directed cases that leave the block on purpose.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
  localparam logic [7:0] CMD_SETUP    = 8'h80;
  localparam logic [7:0] CMD_CACHE_GO = 8'h15;
  localparam logic [7:0] CMD_PAGE_GO  = 8'h10;
  localparam logic [7:0] CMD_STATUS   = 8'h70;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_WAIT, S_XFER, S_FINISH
  } cp_state_t;
endpackage

// File: rtl/nand_cp_front.sv
module nand_cp_front
  import nand_cp_pkg::*;
#(
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int ROW_W           = 4,
  parameter int MAX_SEQ         = 64,
  parameter int XFER_CYC        = 4,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int LD_W  = $clog2(PAGE_BYTES + 1),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int SQ_W  = $clog2(MAX_SEQ + 1),
  localparam int XC_W  = $clog2(XFER_CYC + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_wr,
  input  logic                    addr_wr,
  input  logic                    data_wr,
  input  logic [7:0]              io_in,
  input  logic                    arr_busy,
  output logic                    arr_start,
  output logic [PAGE_BYTES*8-1:0] cache_flat,
  output logic [ROW_W-1:0]        page_row,
  output logic                    page_bad,
  output logic                    busy_o,
  output logic                    final_q
);
  cp_state_t          state;
  logic [1:0]         acnt;
  logic [LD_W-1:0]    ld_cnt;
  logic [XC_W-1:0]    xcnt;
  logic               seq_on;
  logic [ROW_W-PG_W-1:0] seq_blk;
  logic [SQ_W-1:0]    seq_cnt;
  logic [7:0]         cache [PAGE_BYTES];
  logic               loading, wr_byte, confirm;
  logic [ROW_W-PG_W-1:0] blk_new;

  assign loading = (state == S_IDLE) || (state == S_ADDR) || (state == S_DATA);
  assign confirm = cmd_wr && (state == S_DATA) &&
                   ((io_in == CMD_CACHE_GO) || (io_in == CMD_PAGE_GO));
  assign wr_byte = data_wr && !cmd_wr && (state == S_DATA) && (ld_cnt < LD_W'(PAGE_BYTES));
  assign blk_new = page_row[ROW_W-1:PG_W];
  assign arr_start = (state == S_XFER) && (xcnt == XC_W'(XFER_CYC - 1));
  assign busy_o = !loading;

  always_ff @(posedge clk) begin
    if (wr_byte) cache[ld_cnt[COL_W-1:0]] <= io_in;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pad
    assign cache_flat[g*8 +: 8] = (LD_W'(g) < ld_cnt) ? cache[g] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      acnt     <= '0;
      ld_cnt   <= '0;
      page_row <= '0;
      xcnt     <= '0;
      final_q  <= 1'b0;
      seq_on   <= 1'b0;
      seq_blk  <= '0;
      seq_cnt  <= '0;
      page_bad <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_ADDR, S_DATA: begin
          if (cmd_wr && io_in == CMD_SETUP) begin
            state  <= S_ADDR;
            acnt   <= '0;
            ld_cnt <= '0;
          end else if (confirm) begin
            state   <= S_WAIT;
            final_q <= (io_in == CMD_PAGE_GO);
            seq_on  <= (io_in == CMD_CACHE_GO);
            if (!seq_on) begin
              seq_blk  <= blk_new;
              seq_cnt  <= SQ_W'(1);
              page_bad <= 1'b0;
            end else begin
              page_bad <= (blk_new != seq_blk) || (seq_cnt >= SQ_W'(MAX_SEQ));
              if (seq_cnt < SQ_W'(MAX_SEQ)) seq_cnt <= seq_cnt + 1'b1;
            end
          end else if (addr_wr && !cmd_wr && state == S_ADDR) begin
            if (acnt == 2'd2) page_row <= io_in[ROW_W-1:0];
            if (acnt == 2'd3) state <= S_DATA;
            acnt <= acnt + 1'b1;
          end else if (wr_byte) begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        S_WAIT: if (!arr_busy) begin
          state <= S_XFER;
          xcnt  <= '0;
        end
        S_XFER: begin
          if (arr_start) state <= final_q ? S_FINISH : S_IDLE;
          else           xcnt  <= xcnt + 1'b1;
        end
        S_FINISH: if (!arr_busy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_load_bound: assert property (@(posedge clk) disable iff (rst)
    ld_cnt <= LD_W'(PAGE_BYTES));
  a_r11_seq_cap: assert property (@(posedge clk) disable iff (rst)
    seq_cnt <= SQ_W'(MAX_SEQ));
  a_r7_start_idle: assert property (@(posedge clk) disable iff (rst)
    arr_start |-> !arr_busy);
endmodule

// File: rtl/nand_cp_array.sv
module nand_cp_array #(
  parameter int PAGE_BYTES = 16,
  parameter int ROW_W      = 4,
  parameter int PROG_CYC   = 24,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int MEM_AW = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(PROG_CYC + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PAGE_BYTES*8-1:0] cache_flat,
  input  logic [ROW_W-1:0]        row_in,
  input  logic                    bad_in,
  input  logic                    err_in,
  input  logic [MEM_AW-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy,
  output logic                    sr_cur,
  output logic                    sr_prev
);
  logic [PAGE_BYTES*8-1:0] pb_flat;
  logic [ROW_W-1:0]        pb_row;
  logic                    pb_bad, pb_inj;
  logic [CNT_W-1:0]        cnt;
  logic [7:0]              mem [2**MEM_AW];
  logic                    we;
  logic [MEM_AW-1:0]       wa;

  assign we = busy && (cnt < CNT_W'(PAGE_BYTES)) && !pb_bad;
  assign wa = {pb_row, cnt[COL_W-1:0]};

  always_ff @(posedge clk) begin
    if (start) pb_flat <= cache_flat;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= pb_flat[{cnt[COL_W-1:0], 3'b000} +: 8];
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      pb_row  <= '0;
      pb_bad  <= 1'b0;
      pb_inj  <= 1'b0;
      sr_cur  <= 1'b0;
      sr_prev <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      pb_row <= row_in;
      pb_bad <= bad_in;
      pb_inj <= err_in;
    end else if (busy) begin
      if (cnt == CNT_W'(PROG_CYC - 1)) begin
        busy    <= 1'b0;
        sr_prev <= sr_cur;
        sr_cur  <= pb_bad | pb_inj;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt < CNT_W'(PROG_CYC));
endmodule

// File: rtl/nand_cachepgm_ctl.sv
module nand_cachepgm_ctl
  import nand_cp_pkg::*;
#(
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int BLOCKS          = 4,
  parameter int MAX_SEQ         = 64,
  parameter int XFER_CYC        = 4,
  parameter int PROG_CYC        = 24,
  localparam int ROW_W  = $clog2(PAGES_PER_BLOCK * BLOCKS),
  localparam int MEM_AW = ROW_W + $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic [7:0]        io_in,
  input  logic              err_inject,
  output logic [7:0]        io_out,
  output logic              busy_o,
  input  logic [MEM_AW-1:0] mem_rd_addr,
  output logic [7:0]        mem_rd_data
);
  logic                    arr_start, arr_busy, page_bad, final_q;
  logic                    sr_cur, sr_prev, stat_mode;
  logic [PAGE_BYTES*8-1:0] cache_flat;
  logic [ROW_W-1:0]        page_row;
  logic [7:0]              status;

  nand_cp_front #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .ROW_W(ROW_W),
    .MAX_SEQ(MAX_SEQ), .XFER_CYC(XFER_CYC)
  ) u_front (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .addr_wr(addr_wr), .data_wr(data_wr),
    .io_in(io_in), .arr_busy(arr_busy), .arr_start(arr_start),
    .cache_flat(cache_flat), .page_row(page_row), .page_bad(page_bad),
    .busy_o(busy_o), .final_q(final_q)
  );

  nand_cp_array #(
    .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .PROG_CYC(PROG_CYC)
  ) u_array (
    .clk(clk), .rst(rst), .start(arr_start), .cache_flat(cache_flat),
    .row_in(page_row), .bad_in(page_bad), .err_in(err_inject),
    .rd_addr(mem_rd_addr), .rd_data(mem_rd_data), .busy(arr_busy),
    .sr_cur(sr_cur), .sr_prev(sr_prev)
  );

  assign status = {1'b1, !busy_o, !busy_o && !arr_busy, 3'b000, sr_prev, sr_cur};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_mode <= 1'b0;
      io_out    <= 8'h00;
    end else begin
      if (cmd_wr) stat_mode <= (io_in == CMD_STATUS);
      io_out <= stat_mode ? status : 8'h00;
    end
  end

  a_r8_final_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && final_q) |-> !arr_busy);
endmodule

// File: tb/nand_cachepgm_ctl_tb.sv
module nand_cachepgm_ctl_tb;
  localparam int PB = 16;
  localparam int PPB = 4;
  localparam int NROW = 16;
  localparam int MAXS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_wr = 0, addr_wr = 0, data_wr = 0, err_inject = 0;
  logic [7:0] io_in = 0;
  logic [7:0] io_out, mem_rd_data;
  logic busy_o;
  logic [7:0] mem_rd_addr = 0;

  int checks = 0, errs = 0;
  bit done = 0;

  logic [7:0] ref_mem [NROW*PB];
  bit         ref_ok  [NROW*PB];
  bit s_on = 0; int s_blk = 0; int s_cnt = 0;
  bit m_cur = 0, m_prev = 0, pend = 0, pend_v = 0;

  always #10 clk = ~clk;

  nand_cachepgm_ctl #(.MAX_SEQ(MAXS)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .addr_wr(addr_wr), .data_wr(data_wr),
    .io_in(io_in), .err_inject(err_inject), .io_out(io_out), .busy_o(busy_o),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] exp_stat(bit cr, bit ar, bit p, bit c);
    return {1'b1, cr, ar, 3'b000, p, c};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(logic [7:0] b, int kind);
    @(negedge clk);
    io_in = b;
    cmd_wr = (kind == 0); addr_wr = (kind == 1); data_wr = (kind == 2);
    @(negedge clk);
    cmd_wr = 0; addr_wr = 0; data_wr = 0;
  endtask

  task automatic wait_ready();
    int t = 0;
    while (busy_o && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic read_status(output logic [7:0] s);
    bus(8'h70, 0);
    @(negedge clk);
    s = io_out;
  endtask

  // One page: setup, address, n data bytes, confirm (10h if fin else 15h)
  task automatic load_page(int row, int n, bit fin, bit err, bit mid_chk);
    logic [7:0] pat [32];
    logic [7:0] s;
    int blk;
    bit bad;
    bus(8'h80, 0);
    bus(8'h5A, 1); bus(8'hA5, 1); bus(8'(row), 1); bus(8'hC3, 1);
    chk(io_out == 8'h00, "R6 io_out idle", io_out, 0);
    for (int i = 0; i < n; i++) begin
      pat[i] = 8'($urandom_range(0, 255));
      bus(pat[i], 2);
    end
    blk = row / PPB;
    if (!s_on) begin bad = 0; s_blk = blk; s_cnt = 1; end
    else begin bad = (blk != s_blk) || (s_cnt >= MAXS); if (s_cnt < MAXS) s_cnt++; end
    s_on = !fin;
    if (!bad)
      for (int i = 0; i < PB; i++) begin
        ref_mem[row*PB+i] = (i < n) ? pat[i] : 8'hFF;  // R3 padding / truncation
        ref_ok[row*PB+i] = 1;
      end
    if (pend_v) begin m_prev = m_cur; m_cur = pend; end
    pend = bad | err; pend_v = 1;
    err_inject = err;
    bus(fin ? 8'h10 : 8'h15, 0);
    if (fin) begin
      chk(busy_o == 1'b1, "R4 busy after page confirm", busy_o, 1);
      if (mid_chk) begin
        read_status(s);
        chk(s == exp_stat(0, 0, m_prev, m_cur), "R6 R8 status while busy", s, exp_stat(0, 0, m_prev, m_cur));
      end
      wait_ready();
      err_inject = 0;
      m_prev = m_cur; m_cur = pend; pend_v = 0;
      read_status(s);
      chk(s == exp_stat(1, 1, m_prev, m_cur), "R9 R8 status after final", s, exp_stat(1, 1, m_prev, m_cur));
    end else begin
      wait_ready();
      err_inject = 0;
      read_status(s);
      chk(s == exp_stat(1, 0, m_prev, m_cur), "R5 cache ready array busy", s, exp_stat(1, 0, m_prev, m_cur));
    end
  endtask

  task automatic check_row(int row, string req);  // R12 readback
    for (int i = 0; i < PB; i++) begin
      if (ref_ok[row*PB+i]) begin
        @(negedge clk); mem_rd_addr = 8'(row*PB+i);
        @(negedge clk); @(negedge clk);
        chk(mem_rd_data == ref_mem[row*PB+i], req, mem_rd_data, ref_mem[row*PB+i]);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    logic [7:0] s;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NROW*PB; i++) ref_ok[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    chk(io_out == 8'h00, "R1 io_out at reset", io_out, 0);
    read_status(s);
    chk(s == 8'hE0, "R1 status at reset", s, 8'hE0);

    // R2 R4: full page, single 10h program
    load_page(1, 16, 1, 0, 1);
    check_row(1, "R2 R4 row1 contents");
    // R3: short and over-long loads
    load_page(2, 5, 1, 0, 1);
    check_row(2, "R3 padded row2");
    load_page(3, 20, 1, 0, 1);
    check_row(3, "R3 truncated row3");

    // R5 R7: cache sequence within block 1
    load_page(4, 16, 0, 0, 0);
    load_page(5, 9, 0, 0, 0);
    load_page(6, 16, 0, 0, 0);
    load_page(7, 12, 1, 0, 0);
    for (int r = 4; r < 8; r++) check_row(r, "R7 cache sequence rows");

    // R10: second page leaves block; row1 must keep its data
    load_page(8, 16, 0, 0, 0);
    load_page(1, 16, 1, 0, 0);
    read_status(s);
    chk(s == 8'hE1, "R10 out of block flags current", s, 8'hE1);
    check_row(1, "R10 row1 untouched");
    check_row(8, "R10 row8 written");

    // R9: injected error moves from current to previous
    load_page(12, 16, 0, 1, 0);
    load_page(13, 16, 1, 0, 0);
    read_status(s);
    chk(s == 8'hE2, "R9 error shifted to previous", s, 8'hE2);
    load_page(14, 16, 1, 1, 1);
    read_status(s);
    chk(s == 8'hE1, "R9 error on current page", s, 8'hE1);

    // R11: fifth page of a sequence refused
    load_page(8, 16, 0, 0, 0);
    load_page(9, 16, 0, 0, 0);
    load_page(10, 16, 0, 0, 0);
    load_page(11, 16, 0, 0, 0);
    load_page(8, 16, 1, 0, 0);
    read_status(s);
    chk(s == 8'hE1, "R11 cap flags error", s, 8'hE1);
    for (int r = 8; r < 12; r++) check_row(r, "R11 rows after cap");

    // Random sequences inside one block
    for (int k = 0; k < 6; k++) begin
      int blk = $urandom_range(0, 3);
      int np = $urandom_range(1, 3);
      for (int p = 0; p < np; p++)
        load_page(blk*PPB + $urandom_range(0, 3), $urandom_range(1, 20), p == np-1, 0, 0);
    end
    for (int r = 0; r < NROW; r++) check_row(r, "R12 R7 final array");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R4 actual=hung expected=ready");
      summary();
      $finish;
    end
  end
endmodule